// File: doc/BRIEF.md
# Microcoded Sequencer for a Shift-Free Repeated-Addition Multiplier

This block sequences a small multiplier datapath that forms a product by adding the multiplicand into an accumulator once per unit of the multiplier. It does not use a fixed state machine. A three-bit microprogram counter addresses a six-word control store held as a constant inside the block. The word at the current address is loaded into a control word register. Three things in that word act together: a seven-bit control field, a two-bit condition selector and a three-bit branch target. The selector picks a branch condition: never, multiplier not yet zero, or always. When the condition holds, the counter loads the branch target. When it does not, the counter steps to the next address.

The datapath drives the zero input high while its multiplier register holds zero. The seven control outputs drive the datapath's load, clear, add, decrement and output-enable lines directly. In order, the microprogram does three things. It clears the accumulator and loads the multiplicand. It loads the multiplier. It then loops on add-and-decrement until the zero input rises. After the loop it presents the accumulator once and parks in a halt word that jumps to itself. Reset returns the program to its first word.

Top module: `mult_useq`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the control word is the one at address 0: `ctrl` equals 7'b0000011 (clear accumulator on bit 0, load multiplicand on bit 1).
- R2: A control store word is 12 bits: selector in bits 11:10, branch target in bits 9:7, and control field in bits 6:0, with field bit i driving `ctrl[i]`. The output-enable bit 5 is never asserted together with another control bit.
- R3: Without a branch the program runs straight through addresses 0, 1, 2, 3. Address 1 gives `ctrl` = 7'b0000100 (load multiplier), and address 2 gives 7'b1011000 (add on bit 3, decrement on bit 4, accumulator write on bit 6).
- R4: At address 3 (selector 01, target 2, no controls), a low `zero` input sampled at the clock edge sends the next cycle back to address 2.
- R5: At address 3, a high `zero` input makes the next cycle address 4, which gives `ctrl` = 7'b0100000 for exactly one cycle.
- R6: Address 5 (selector 10, target 5, no controls) is a halt: once reached, the program stays there with `ctrl` all zero until reset, whatever `zero` does.
- R7: Words with selector 00 (and the unused selector 11) never branch, so `zero` has no effect on the sequence except at address 3. Control store addresses beyond 5 are never reached.
- R8: A datapath driven by these outputs ends with the product of multiplicand and multiplier on its output bus, for every multiplier from 1 to 15. The control sequence matches a six-state hardwired controller cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to address 0 |
| zero | input | 1 | High while the datapath multiplier register is zero |
| ctrl | output | 7 | Registered control lines, bit i is control line i |

## Verification
The hardest situation to reach is proving that `zero` matters only at the decision word and nowhere else. A datapath drives `zero` honestly only at the loop test. At every other word, including the halt, the stimulus drives it with a pattern that depends on the operands and the cycle number. Any leak of the flag would bend the control trace away from the hardwired model. The sweep covers every multiplicand from 0 to 15 against every multiplier from 1 to 15, so the loop runs from one iteration up to its longest count.

// File: rtl/mult_useq.sv
module mult_useq #(
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 2,
  parameter int CTRL_W = 7,
  parameter int WORDS  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zero,
  output logic [CTRL_W-1:0] ctrl
);
  localparam int WORD_W = SEL_W + ADDR_W + CTRL_W;
  localparam logic [ADDR_W-1:0] HALT_A = ADDR_W'(WORDS - 1);
  localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);

  function automatic logic [WORD_W-1:0] store(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_W'(0): store = {SEL_W'(0), ADDR_W'(0), CTRL_W'(7'b0000011)};
      ADDR_W'(1): store = {SEL_W'(0), ADDR_W'(0), CTRL_W'(7'b0000100)};
      ADDR_W'(2): store = {SEL_W'(0), ADDR_W'(0), CTRL_W'(7'b1011000)};
      ADDR_W'(3): store = {SEL_W'(1), ADDR_W'(2), CTRL_W'(0)};
      ADDR_W'(4): store = {SEL_W'(0), ADDR_W'(0), CTRL_W'(7'b0100000)};
      default:    store = {SEL_W'(2), HALT_A,     CTRL_W'(0)};
    endcase
  endfunction

  logic [ADDR_W-1:0] upc_q, upc_d;
  logic [WORD_W-1:0] cw_q;
  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] target;
  logic              take;

  assign sel    = cw_q[WORD_W-1 -: SEL_W];
  assign target = cw_q[CTRL_W +: ADDR_W];
  assign ctrl   = cw_q[CTRL_W-1:0];

  always_comb begin
    case (sel)
      SEL_W'(1): take = !zero;
      SEL_W'(2): take = 1'b1;
      default:   take = 1'b0;
    endcase
  end

  assign upc_d = take ? target : upc_q + ONE_A;

  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q <= '0;
      cw_q  <= store('0);
    end else begin
      upc_q <= upc_d;
      cw_q  <= store(upc_d);
    end
  end

  a_r1_reset_word: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (upc_q == '0 && ctrl == CTRL_W'(7'b0000011)));
  a_r2_out_alone: assert property (@(posedge clk) disable iff (rst)
    ctrl[5] |-> ($countones(ctrl) == 1));
  a_r3_straight: assert property (@(posedge clk) disable iff (rst)
    (upc_q == ADDR_W'(1)) |=> (upc_q == ADDR_W'(2) && ctrl == CTRL_W'(7'b1011000)));
  a_r4_loop_back: assert property (@(posedge clk) disable iff (rst)
    (upc_q == ADDR_W'(3) && !zero) |=> (upc_q == ADDR_W'(2)));
  a_r5_loop_exit: assert property (@(posedge clk) disable iff (rst)
    (upc_q == ADDR_W'(3) && zero) |=> (ctrl == CTRL_W'(7'b0100000)));
  a_r6_halt_hold: assert property (@(posedge clk) disable iff (rst)
    (upc_q == HALT_A) |=> (upc_q == HALT_A && ctrl == '0));
  a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
    upc_q <= HALT_A);
endmodule

// File: tb/mult_useq_tb.sv
module mult_useq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       zero = 1'b0;
  logic [6:0] ctrl;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mult_useq dut_i (.clk(clk), .rst(rst), .zero(zero), .ctrl(ctrl));

  function automatic logic [6:0] exp_ctrl(input int t);
    case (t)
      0: exp_ctrl = 7'b0000011;
      1: exp_ctrl = 7'b0000100;
      2: exp_ctrl = 7'b1011000;
      4: exp_ctrl = 7'b0100000;
      default: exp_ctrl = 7'b0000000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, expv, $time);
    end
  endtask

  task automatic run(input int m, input int qv);
    int t;
    int prev;
    logic [3:0] mreg, q;
    logic [7:0] r, outv;
    int outs;
    logic [6:0] e;
    rst = 1'b1;
    zero = 1'b0;
    q = 4'd7; r = 8'd0; mreg = 4'd0; outv = 8'd0; outs = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(ctrl == exp_ctrl(0), "R1 reset word", ctrl, exp_ctrl(0));
    rst = 1'b0;
    t = 0;
    check(ctrl == exp_ctrl(0), "R1 first cycle", ctrl, exp_ctrl(0));
    for (int k = 0; k < 2 * qv + 10; k++) begin
      if (t == 3) zero = (q == 4'd0);
      else zero = 1'(((m * 7) ^ (qv * 3) ^ k) & 1);
      @(posedge clk);
      e = exp_ctrl(t);
      if (e[0]) r = 8'd0;
      if (e[1]) mreg = 4'(m);
      if (e[2]) q = 4'(qv);
      if (e[3] && e[6]) r = r + {4'd0, mreg};
      if (e[4]) q = q - 4'd1;
      if (e[5]) begin outv = r; outs++; end
      prev = t;
      case (t)
        0: t = 1;
        1: t = 2;
        2: t = 3;
        3: t = zero ? 4 : 2;
        default: t = 5;
      endcase
      @(negedge clk);
      if (prev == 3 && t == 2)      check(ctrl == exp_ctrl(t), "R4 loop back", ctrl, exp_ctrl(t));
      else if (prev == 3)           check(ctrl == exp_ctrl(t), "R5 loop exit", ctrl, exp_ctrl(t));
      else if (prev >= 4)           check(ctrl == exp_ctrl(t), "R6 halt (R7 zero ignored)", ctrl, exp_ctrl(t));
      else                          check(ctrl == exp_ctrl(t), "R3 straight (R7 zero ignored)", ctrl, exp_ctrl(t));
      if (ctrl[5]) check($countones(ctrl) == 1, "R2 output bit alone", ctrl, 32);
    end
    check(outs == 1, "R5 single output cycle", outs, 1);
    check(int'(outv) == m * qv, "R8 product", outv, m * qv);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 16; m++)
      for (int qv = 1; qv < 16; qv++)
        run(m, qv);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule